// File: doc/BRIEF.md
# Generator Instruction Dispatcher

This block reads instruction frames from a two-port instruction RAM and hands their payload words to a bank of parallel waveform generators. The host loads frames through a write port. A sequencing state machine then gives a start address, an instruction count and a run request. The dispatcher walks the frames in address order. It decodes the one-word header of each frame, then streams the payload words to the addressed generator, one word per clock, with a one-hot valid strobe.

Generator index 0 is a control generator for the whole channel, and frames address it like any other generator. Its payload words set three masks:

- clock enables for the other generators,
- one-cycle counter-reset pulses,
- output enables.

The block also forms the channel sample. This is the saturating sum of the sample inputs of generators 1 and up, where each one is gated by its output enable. Generator 0's own sample input never enters the sum.

Top module: `gen_frame_dispatch`

## Requirements
- R1: A header word carries the target generator id in bits [7:0] and the payload length in words in bits [23:8]. The payload words that follow it in RAM appear in address order on `genData`, together with a `genValid` that is one-hot at bit id.
- R2: The payload words of one frame are delivered on consecutive clock cycles, one word per cycle.
- R3: A run request taken while idle dispatches `instrCount` frames laid back to back from `startAddr`. After the last one, `donePulse` is high for exactly one cycle, and `busy` is low on the following cycle.
- R4: A run with `instrCount` equal to 0 raises `donePulse` once and produces no valid strobe.
- R5: A frame whose id is at or above `NUM_GEN` is skipped whole. It raises no strobe, its payload words are not read as headers, and `errSticky` is set and stays set until reset.
- R6: A frame of length 0 raises no strobe but still counts as one instruction.
- R7: Frames for generator 0 raise `genValid[0]`. In each such payload word, bit 8+g drives `ctlCntRst[g]` in the same cycle as the strobe. Bits g and 16+g load `ctlClkEn[g]` and `ctlOutEn[g]` on the next clock.
- R8: `chanSum` is registered. It is the sum of the signed samples of generators 1..NUM_GEN-1 whose output enable is set. Generator 0's sample is always excluded.
- R9: The sum saturates at +32767 and -32768 instead of wrapping (16-bit output).
- R10: After reset the block is idle: no strobe, no done, no error, all masks zero, sum zero.
- R11: Header bits [31:24] appear on `genFlags` during that frame's payload strobes.
- R12: A run request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write enable for the instruction RAM |
| hostAddr | input | ADDR_W | Host write address |
| hostData | input | 32 | Host write data |
| runEn | input | 1 | Run request from the sequencer |
| startAddr | input | ADDR_W | Address of the first header |
| instrCount | input | ADDR_W+1 | Number of frames to dispatch |
| genSamples | input | NUM_GEN*SAMPLE_W | Signed sample of each generator, generator g at slice g |
| busy | output | 1 | A run is in progress |
| donePulse | output | 1 | One-cycle pulse at the end of a run |
| errSticky | output | 1 | A frame with an unknown id was seen |
| genValid | output | NUM_GEN | One-hot payload strobe |
| genData | output | 32 | Payload word |
| genFlags | output | 8 | Flag byte of the current frame |
| ctlClkEn | output | NUM_GEN-1 | Clock enables of generators 1.. |
| ctlCntRst | output | NUM_GEN-1 | Counter reset pulses of generators 1.. |
| ctlOutEn | output | NUM_GEN-1 | Output enables of generators 1.. |
| chanSum | output | OUT_W | Saturated, gated channel sum |

## Verification
A corrupted read pointer or remaining-word counter does not stay hidden. It sends payload words to the wrong generator, or makes a payload word act as a header, so the strobe sequence diverges within a frame or two of the fault. A wrong frame counter shows as a `donePulse` that comes early, late or never. This is caught because each run expects an exact list of strobes and exactly one done pulse. A wrong gate mask or a missing clamp appears on `chanSum` two cycles after the control word is delivered.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int WORD_W      = 32;
  localparam int ID_W        = 8;
  localparam int LEN_W       = 16;
  localparam int FLG_W       = 8;
  localparam int HDR_ID_LSB  = 0;
  localparam int HDR_LEN_LSB = 8;
  localparam int HDR_FLG_LSB = 24;
  // control generator payload fields, bit g of each field belongs to generator g
  localparam int CTL_CLK_LSB = 0;
  localparam int CTL_RST_LSB = 8;
  localparam int CTL_OE_LSB  = 16;

  typedef struct packed {
    logic            fetchPay;
    logic [ID_W-1:0] payId;
    logic            hdrLoad;
  } dispStrb_t;
endpackage

// File: rtl/frame_ram.sv
module frame_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    rData <= mem[rAddr];
  end
endmodule

// File: rtl/sat_summer.sv
module sat_summer #(
  parameter int NUM_GEN  = 4,
  parameter int SAMPLE_W = 16,
  parameter int OUT_W    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_GEN*SAMPLE_W-1:0]   samples,
  input  logic [NUM_GEN-1:1]            outEn,
  output logic signed [OUT_W-1:0]       sum
);
  localparam int ACC_W = SAMPLE_W + OUT_W + $clog2(NUM_GEN);
  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc;
  logic signed [OUT_W-1:0] clamped;

  always_comb begin
    acc = '0;
    for (int g = 1; g < NUM_GEN; g++) begin
      if (outEn[g]) acc = acc + ACC_W'($signed(samples[g*SAMPLE_W +: SAMPLE_W]));
    end
    if (acc > SAT_HI)      clamped = SAT_HI[OUT_W-1:0];
    else if (acc < SAT_LO) clamped = SAT_LO[OUT_W-1:0];
    else                   clamped = acc[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) sum <= '0;
    else       sum <= clamped;
  end

  // R8: with every gate closed the registered sum is zero
  a_r8_gated_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outEn == '0) |=> (sum == '0));
endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_pkg::*;
#(
  parameter int NUM_GEN  = 4,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int OUT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostWe,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [WORD_W-1:0]           hostData,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  dispStrb_t                   strb,
  input  logic [NUM_GEN*SAMPLE_W-1:0] genSamples,
  output logic [WORD_W-1:0]           ramQ,
  output logic [NUM_GEN-1:0]          genValid,
  output logic [WORD_W-1:0]           genData,
  output logic [FLG_W-1:0]            genFlags,
  output logic [NUM_GEN-1:1]          ctlClkEn,
  output logic [NUM_GEN-1:1]          ctlCntRst,
  output logic [NUM_GEN-1:1]          ctlOutEn,
  output logic signed [OUT_W-1:0]     chanSum
);
  logic            pendValid;
  logic [ID_W-1:0] pendId;
  logic [FLG_W-1:0] flagReg;

  frame_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
    .clk(clk), .we(hostWe), .wAddr(hostAddr), .wData(hostData),
    .rAddr(rdAddr), .rData(ramQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendId    <= '0;
      flagReg   <= '0;
    end else begin
      pendValid <= strb.fetchPay;
      pendId    <= strb.payId;
      if (strb.hdrLoad) flagReg <= ramQ[HDR_FLG_LSB +: FLG_W];
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_valid
    assign genValid[g] = pendValid && (pendId == ID_W'(g));
  end

  assign genData  = ramQ;
  assign genFlags = flagReg;

  // control generator: masks latch, reset pulses pass through with the strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlClkEn <= '0;
      ctlOutEn <= '0;
    end else if (genValid[0]) begin
      ctlClkEn <= ramQ[CTL_CLK_LSB+1 +: NUM_GEN-1];
      ctlOutEn <= ramQ[CTL_OE_LSB+1  +: NUM_GEN-1];
    end
  end

  assign ctlCntRst = genValid[0] ? ramQ[CTL_RST_LSB+1 +: NUM_GEN-1] : '0;

  sat_summer #(.NUM_GEN(NUM_GEN), .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_sum (
    .clk(clk), .rstN(rstN), .samples(genSamples), .outEn(ctlOutEn), .sum(chanSum)
  );

  // R1: at most one generator strobed per cycle
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(genValid));
  // R7: masks move only after a control-generator strobe
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !genValid[0] |=> $stable(ctlOutEn) && $stable(ctlClkEn));
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
#(
  parameter int NUM_GEN = 4,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  instrCount,
  input  logic [WORD_W-1:0] ramQ,
  output logic [ADDR_W-1:0] rdAddr,
  output dispStrb_t         strb,
  output logic              busy,
  output logic              donePulse,
  output logic              errSticky
);
  typedef enum logic [2:0] {S_IDLE, S_HREAD, S_HDEC, S_PAY, S_DONE} state_t;
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_GEN - 1);

  state_t            state;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  instrLeft;
  logic [LEN_W-1:0]  wordsLeft;
  logic [ID_W-1:0]   curId;
  logic [ID_W-1:0]   hdrId;
  logic [LEN_W-1:0]  hdrLen;
  logic              idBad;

  assign hdrId  = ramQ[HDR_ID_LSB  +: ID_W];
  assign hdrLen = ramQ[HDR_LEN_LSB +: LEN_W];
  assign idBad  = hdrId > LAST_ID;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      ptr       <= '0;
      instrLeft <= '0;
      wordsLeft <= '0;
      curId     <= '0;
      errSticky <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (runEn) begin
          ptr       <= startAddr;
          instrLeft <= instrCount;
          state     <= (instrCount == '0) ? S_DONE : S_HREAD;
        end
        S_HREAD: state <= S_HDEC;
        S_HDEC: begin
          instrLeft <= instrLeft - 1'b1;
          if (idBad || hdrLen == '0) begin
            if (idBad) errSticky <= 1'b1;
            ptr   <= ptr + ADDR_W'(1) + ADDR_W'(hdrLen);
            state <= (instrLeft == CNT_W'(1)) ? S_DONE : S_HREAD;
          end else begin
            ptr       <= ptr + ADDR_W'(1);
            wordsLeft <= hdrLen;
            curId     <= hdrId;
            state     <= S_PAY;
          end
        end
        S_PAY: begin
          ptr       <= ptr + ADDR_W'(1);
          wordsLeft <= wordsLeft - 1'b1;
          if (wordsLeft == LEN_W'(1))
            state <= (instrLeft == '0) ? S_DONE : S_HREAD;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.fetchPay = (state == S_PAY);
    strb.payId    = curId;
    strb.hdrLoad  = (state == S_HDEC) && !idBad && (hdrLen != '0);
  end

  assign rdAddr    = ptr;
  assign busy      = (state != S_IDLE);
  assign donePulse = (state == S_DONE);

  // R3: done lasts one cycle and the block is idle right after
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN) donePulse |=> !donePulse);
  a_r3_idle_after:  assert property (@(posedge clk) disable iff (!rstN) donePulse |=> !busy);
  // R5: the error flag never clears outside reset
  a_r5_err_sticky:  assert property (@(posedge clk) disable iff (!rstN) errSticky |=> errSticky);
  // R12: a run starts only from a request
  a_r12_start_req:  assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(runEn));
endmodule

// File: rtl/gen_frame_dispatch.sv
module gen_frame_dispatch
  import frame_pkg::*;
#(
  parameter int NUM_GEN  = 4,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int OUT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostWe,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [31:0]                 hostData,
  input  logic                        runEn,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic [ADDR_W:0]             instrCount,
  input  logic [NUM_GEN*SAMPLE_W-1:0] genSamples,
  output logic                        busy,
  output logic                        donePulse,
  output logic                        errSticky,
  output logic [NUM_GEN-1:0]          genValid,
  output logic [31:0]                 genData,
  output logic [7:0]                  genFlags,
  output logic [NUM_GEN-1:1]          ctlClkEn,
  output logic [NUM_GEN-1:1]          ctlCntRst,
  output logic [NUM_GEN-1:1]          ctlOutEn,
  output logic signed [OUT_W-1:0]     chanSum
);
  localparam int CNT_W = ADDR_W + 1;

  logic [WORD_W-1:0] ramQ;
  logic [ADDR_W-1:0] rdAddr;
  dispStrb_t         strb;

  frame_ctrl #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .startAddr(startAddr),
    .instrCount(instrCount), .ramQ(ramQ), .rdAddr(rdAddr), .strb(strb),
    .busy(busy), .donePulse(donePulse), .errSticky(errSticky)
  );

  frame_datapath #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .rdAddr(rdAddr), .strb(strb), .genSamples(genSamples), .ramQ(ramQ),
    .genValid(genValid), .genData(genData), .genFlags(genFlags),
    .ctlClkEn(ctlClkEn), .ctlCntRst(ctlCntRst), .ctlOutEn(ctlOutEn), .chanSum(chanSum)
  );

  // R2: every payload fetch becomes a strobe on the next cycle
  a_r2_fetch_strobe: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchPay |=> (genValid != '0));
  // R10: no strobe while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (genValid == '0));
endmodule

// File: tb/gen_frame_dispatch_tb.sv
module gen_frame_dispatch_tb;
  localparam int NG = 4;
  localparam int AW = 8;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostData = '0;
  logic runEn = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW:0] instrCount = '0;
  logic [NG*SW-1:0] genSamples = '0;
  logic busy, donePulse, errSticky;
  logic [NG-1:0] genValid;
  logic [31:0] genData;
  logic [7:0] genFlags;
  logic [NG-1:1] ctlClkEn, ctlCntRst, ctlOutEn;
  logic signed [15:0] chanSum;

  gen_frame_dispatch #(.NUM_GEN(NG), .ADDR_W(AW), .SAMPLE_W(SW), .OUT_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .runEn(runEn), .startAddr(startAddr), .instrCount(instrCount), .genSamples(genSamples),
    .busy(busy), .donePulse(donePulse), .errSticky(errSticky), .genValid(genValid),
    .genData(genData), .genFlags(genFlags), .ctlClkEn(ctlClkEn), .ctlCntRst(ctlCntRst),
    .ctlOutEn(ctlOutEn), .chanSum(chanSum)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // monitor of strobes, sampled at negedge
  int evN = 0;
  int doneCnt = 0;
  int cyc = 0;
  int evId [512];
  logic [31:0] evData [512];
  logic [7:0] evFlg [512];
  int evCyc [512];
  logic [NG-1:1] rstAtValid = '0;
  logic [NG-1:1] rstOther = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (donePulse) doneCnt <= doneCnt + 1;
      if (genValid != '0 && evN < 512) begin
        for (int g = 0; g < NG; g++) if (genValid[g]) evId[evN] <= g;
        evData[evN] <= genData;
        evFlg[evN] <= genFlags;
        evCyc[evN] <= cyc;
        evN <= evN + 1;
      end
      if (genValid[0]) rstAtValid <= rstAtValid | ctlCntRst;
      else rstOther <= rstOther | ctlCntRst;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int id, input int len, input int flg);
    return {flg[7:0], len[15:0], id[7:0]};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a[AW-1:0]; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic runProg(input int sa, input int cnt, input bit extraReq);
    int d0;
    d0 = doneCnt;
    @(negedge clk);
    runEn = 1'b1; startAddr = sa[AW-1:0]; instrCount = cnt[AW:0];
    @(negedge clk);
    runEn = 1'b0;
    if (extraReq) begin
      repeat (2) @(negedge clk);
      runEn = 1'b1;
      @(negedge clk);
      runEn = 1'b0;
    end
    for (int i = 0; i < 200 && doneCnt == d0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic setSamples(input int s0, input int s1, input int s2, input int s3);
    genSamples = {s3[15:0], s2[15:0], s1[15:0], s0[15:0]};
  endtask

  task automatic t_reset;
    // R10
    chk(!busy && !donePulse && !errSticky, "R10 idle flags", {busy, donePulse, errSticky}, 0);
    chk(genValid == 0, "R10 no strobe", genValid, 0);
    chk(ctlClkEn == 0 && ctlOutEn == 0 && ctlCntRst == 0, "R10 masks", {ctlClkEn, ctlOutEn, ctlCntRst}, 0);
    chk(chanSum == 0, "R10 sum", chanSum, 0);
  endtask

  task automatic t_basic;
    int b, d0;
    wr(0, hdr(2, 3, 8'hA5)); wr(1, 32'h11); wr(2, 32'h22); wr(3, 32'h33);
    wr(4, hdr(1, 1, 8'h3C)); wr(5, 32'h44);
    b = evN; d0 = doneCnt;
    runProg(0, 2, 0);
    chk(evN - b == 4, "R3 frame count", evN - b, 4);
    chk(doneCnt - d0 == 1, "R3 one done", doneCnt - d0, 1);
    chk(!busy, "R3 idle after done", busy, 0);
    chk(evId[b] == 2 && evData[b] == 32'h11, "R1 first word", evData[b], 32'h11);
    chk(evId[b+2] == 2 && evData[b+2] == 32'h33, "R1 third word", evData[b+2], 32'h33);
    chk(evId[b+3] == 1 && evData[b+3] == 32'h44, "R1 second frame", evId[b+3], 1);
    chk(evCyc[b+1] == evCyc[b] + 1 && evCyc[b+2] == evCyc[b] + 2, "R2 back to back",
        evCyc[b+2] - evCyc[b], 2);
    chk(evFlg[b] == 8'hA5 && evFlg[b+2] == 8'hA5, "R11 flags frame one", evFlg[b], 8'hA5);
    chk(evFlg[b+3] == 8'h3C, "R11 flags frame two", evFlg[b+3], 8'h3C);
  endtask

  task automatic t_zero_count;
    int b, d0;
    b = evN; d0 = doneCnt;
    runProg(0, 0, 0);
    chk(doneCnt - d0 == 1, "R4 done on empty run", doneCnt - d0, 1);
    chk(evN == b, "R4 no strobe", evN - b, 0);
  endtask

  task automatic t_bad_id;
    int b;
    chk(!errSticky, "R5 error clear before", errSticky, 0);
    wr(16, hdr(7, 2, 0)); wr(17, hdr(1, 1, 0)); wr(18, hdr(1, 1, 0));
    wr(19, hdr(1, 1, 0)); wr(20, 32'h1234);
    b = evN;
    runProg(16, 2, 0);
    chk(evN - b == 1, "R5 skipped payload", evN - b, 1);
    chk(evId[b] == 1 && evData[b] == 32'h1234, "R5 next frame intact", evData[b], 32'h1234);
    chk(errSticky, "R5 error set", errSticky, 1);
  endtask

  task automatic t_zero_len;
    int b;
    wr(32, hdr(3, 0, 0)); wr(33, hdr(3, 1, 0)); wr(34, 32'hBEEF);
    b = evN;
    runProg(32, 2, 0);
    chk(evN - b == 1, "R6 empty frame silent", evN - b, 1);
    chk(evId[b] == 3 && evData[b] == 32'hBEEF, "R6 following frame", evData[b], 32'hBEEF);
    chk(errSticky, "R5 error still held", errSticky, 1);
  endtask

  task automatic t_ctl_gen;
    int b;
    setSamples(1000, 100, 200, 400);
    wr(48, hdr(0, 1, 0)); wr(49, (32'h06 << 16) | (32'h04 << 8) | 32'h0E);
    b = evN;
    rstAtValid = '0; rstOther = '0;
    runProg(48, 1, 0);
    chk(evN - b == 1 && evId[b] == 0, "R7 control strobe", evId[b], 0);
    chk(rstAtValid == 3'b010 && rstOther == 0, "R7 reset pulse", {rstOther, rstAtValid}, 2);
    chk(ctlClkEn == 3'b111, "R7 clock enables", ctlClkEn, 7);
    chk(ctlOutEn == 3'b011, "R7 output enables", ctlOutEn, 3);
    chk(chanSum == 300, "R8 gated sum excludes gen0 and gen3", chanSum, 300);
    setSamples(1000, -50, 20, 400);
    repeat (2) @(negedge clk);
    chk(chanSum == -30, "R8 signed sum", chanSum, -30);
  endtask

  task automatic t_saturate;
    wr(56, hdr(0, 1, 0)); wr(57, (32'h0E << 16) | 32'h0E);
    runProg(56, 1, 0);
    setSamples(0, 30000, 30000, 0);
    repeat (2) @(negedge clk);
    chk(chanSum == 32767, "R9 positive clamp", chanSum, 32767);
    setSamples(0, -30000, -30000, -30000);
    repeat (2) @(negedge clk);
    chk(chanSum == -32768, "R9 negative clamp", chanSum, -32768);
    setSamples(0, 1, 2, 3);
    repeat (2) @(negedge clk);
    chk(chanSum == 6, "R8 all gates open", chanSum, 6);
  endtask

  task automatic t_busy_req;
    int b, d0;
    b = evN; d0 = doneCnt;
    runProg(0, 2, 1);
    repeat (20) @(negedge clk);
    chk(doneCnt - d0 == 1, "R12 one run only", doneCnt - d0, 1);
    chk(evN - b == 4, "R12 strobes of one run", evN - b, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_zero_count();
    t_bad_id();
    t_zero_len();
    t_ctl_gen();
    t_saturate();
    t_busy_req();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule